// File: doc/BRIEF.md
# HDB3 Line Code Decoder

This block turns a stream of bipolar line symbols back into the binary data that produced them. Each symbol arrives as a pair of lines, one for a positive pulse and one for a negative pulse, qualified by a strobe. When neither line is high, the symbol is a zero. The decoder tracks the polarity of the most recent pulse. A pulse that repeats that polarity is a deliberate polarity violation, and it is decoded as a zero.

A violation that follows the pattern pulse, zero, zero marks a four-zero substitution group of the balancing kind. The decoder clears the leading pulse as well. To do this it holds the last four symbols in a short window, so every decoded bit leaves the block exactly four strobes after its symbol entered. A code-error flag reports two conditions: both lines high at once, and two successive violations with the same polarity.

Top module: `hdb3_line_decoder`

## Requirements
- R1: A zero symbol decodes to 0. A pulse whose polarity is opposite to the polarity of the previous pulse decodes to 1.
- R2: A pulse with the same polarity as the previous pulse is a violation and decodes to 0. The previous pulse counts whether it was an ordinary mark, a balancing pulse or a violation. After reset, the previous polarity is taken as negative.
- R3: When a violation arrives and the three symbols before it were, oldest first, a pulse, a zero and a zero, that pulse also decodes to 0.
- R4: `dout_valid` is high for exactly the one cycle after an accepted strobe, and only once four earlier symbols have been accepted since reset. `dout_bit` in that cycle carries the decoded value of the symbol accepted four strobes earlier.
- R5: A stream produced by a correct HDB3 encoder, started with its last polarity negative, decodes back to the original data.
- R6: A symbol with both lines high raises `code_err` in the cycle after its strobe. It is decoded as a zero, and it leaves the polarity history unchanged.
- R7: A violation with the same polarity as the violation before it raises `code_err` in the cycle after its strobe.
- R8: Synchronous reset empties the window, sets the previous polarity to negative, forgets earlier violations, and holds `dout_valid` and `code_err` low.
- R9: Cycles with the strobe low change no state and leave `dout_valid` and `code_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Symbol strobe |
| sym_pos | input | 1 | Positive pulse present |
| sym_neg | input | 1 | Negative pulse present |
| dout_valid | output | 1 | Decoded bit valid |
| dout_bit | output | 1 | Decoded data bit |
| code_err | output | 1 | Line code error seen on the last strobe |

## Verification
Two events can fall on the same strobe. The violation that completes a balancing group clears a pulse three positions back in the window. On that same strobe the window releases its oldest symbol. The bench sends balancing groups right after reset and back to back, so the clear, the release and the filling of the window overlap. A behavioural model of the symbol history judges every output cycle. When an encoded stream is sent, the bench also compares each output against the original data.

// File: rtl/hdb3_dec_pkg.sv
package hdb3_dec_pkg;

    // Substitution group length; the window depth follows from it
    localparam int SUB_LEN = 4;
    localparam int FILL_W  = $clog2(SUB_LEN + 1);

    typedef struct packed {
        logic mark;   // symbol was a pulse
        logic one;    // decoded value
    } stage_t;

    typedef struct packed {
        logic last_pos;  // polarity of last pulse, 1 = positive
        logic v_seen;    // a violation has been seen since reset
        logic v_pos;     // polarity of last violation
        logic err;       // registered code error
    } trk_t;

    typedef struct packed {
        stage_t [SUB_LEN-1:0] stg;
        logic [FILL_W-1:0]    fill;
        logic                 ovalid;
        logic                 obit;
    } win_t;

endpackage

// File: rtl/hdb3_pol_tracker.sv
module hdb3_pol_tracker
    import hdb3_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic pos,
    input  logic neg,
    output logic sym_mark,
    output logic sym_viol,
    output logic err
);

    trk_t q, d;
    logic both;

    always_comb begin
        both     = pos & neg;
        sym_mark = valid & (pos ^ neg);
        sym_viol = sym_mark & (pos == q.last_pos);
        d        = q;
        d.err    = 1'b0;
        if (valid) begin
            if (both) d.err = 1'b1;
            if (sym_mark) begin
                if (sym_viol) begin
                    if (q.v_seen && (q.v_pos == pos)) d.err = 1'b1;
                    d.v_seen = 1'b1;
                    d.v_pos  = pos;
                end
                d.last_pos = pos;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign err = q.err;

    // R6
    both_err_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && pos && neg) |=> err);

    // R2
    pol_track_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (pos ^ neg)) |=> (q.last_pos == $past(pos)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (!err && q.last_pos == $past(q.last_pos)));

endmodule

// File: rtl/hdb3_sub_window.sv
module hdb3_sub_window
    import hdb3_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic mark,
    input  logic viol,
    output logic out_valid,
    output logic out_bit
);

    win_t q, d;
    logic bal_hit;

    always_comb begin
        d        = q;
        d.ovalid = 1'b0;
        bal_hit  = viol && q.stg[2].mark && !q.stg[1].mark && !q.stg[0].mark;
        if (valid) begin
            d.obit   = q.stg[SUB_LEN-1].one;
            d.ovalid = (q.fill == FILL_W'(SUB_LEN));
            if (q.fill != FILL_W'(SUB_LEN)) d.fill = q.fill + 1'b1;
            for (int i = SUB_LEN - 1; i > 0; i--) begin
                d.stg[i] = q.stg[i-1];
            end
            d.stg[0].mark = mark;
            d.stg[0].one  = mark & ~viol;
            if (bal_hit) d.stg[SUB_LEN-1].one = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ovalid;
    assign out_bit   = q.obit;

    // R2
    viol_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && viol) |=> !q.stg[0].one);

    // R3
    bal_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && viol && q.stg[2].mark && !q.stg[1].mark && !q.stg[0].mark)
        |=> !q.stg[SUB_LEN-1].one);

    // R4
    out_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(valid));

endmodule

// File: rtl/hdb3_line_decoder.sv
module hdb3_line_decoder
    import hdb3_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sym_valid,
    input  logic sym_pos,
    input  logic sym_neg,
    output logic dout_valid,
    output logic dout_bit,
    output logic code_err
);

    logic mark, viol;

    hdb3_pol_tracker u_trk (
        .clk      (clk),
        .rst      (rst),
        .valid    (sym_valid),
        .pos      (sym_pos),
        .neg      (sym_neg),
        .sym_mark (mark),
        .sym_viol (viol),
        .err      (code_err)
    );

    hdb3_sub_window u_win (
        .clk       (clk),
        .rst       (rst),
        .valid     (sym_valid),
        .mark      (mark),
        .viol      (viol),
        .out_valid (dout_valid),
        .out_bit   (dout_bit)
    );

    // R8
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!dout_valid && !code_err));

    // R4
    bit_valid_chk: assert property (@(posedge clk) disable iff (rst)
        dout_bit |-> dout_valid || $stable(dout_bit));

endmodule

// File: tb/hdb3_line_decoder_bench.sv
module hdb3_line_decoder_bench;

    logic clk = 1'b0;
    logic rst, sym_valid, sym_pos, sym_neg;
    logic dout_valid, dout_bit, code_err;

    always #2.5 clk = ~clk;

    hdb3_line_decoder u_hdb3_line_decoder (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_pos(sym_pos),
        .sym_neg(sym_neg), .dout_valid(dout_valid), .dout_bit(dout_bit),
        .code_err(code_err)
    );

    int total = 0;
    int bad   = 0;

    // reference model state
    int mk[$];
    int bt[$];
    int lastp;
    int vseen;
    int vpol;
    int orig[$];
    int use_orig;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mk.delete(); bt.delete(); orig.delete();
        lastp = -1; vseen = 0; vpol = 0; use_orig = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sym_valid = 1'b0; sym_pos = 1'b0; sym_neg = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 valid after reset", int'(dout_valid), 0);
        chk("R8 err after reset", int'(code_err), 0);
        rst = 1'b0;
        model_reset();
    endtask

    // s: -1 negative, 0 zero, 1 positive, 2 both lines
    task automatic send(input int s);
        int n, e_err, e_val, e_bit, is_v;
        sym_valid = 1'b1;
        sym_pos = (s == 1 || s == 2);
        sym_neg = (s == -1 || s == 2);
        e_err = (s == 2);
        n = mk.size();
        if (s == 1 || s == -1) begin
            is_v = (s == lastp);
            if (is_v) begin
                if (vseen && vpol == s) e_err = 1;
                vseen = 1; vpol = s;
                if (n >= 3 && mk[n-3] && !mk[n-2] && !mk[n-1]) bt[n-3] = 0;
            end
            lastp = s;
            mk.push_back(1); bt.push_back(is_v ? 0 : 1);
        end else begin
            mk.push_back(0); bt.push_back(0);
        end
        e_val = (n >= 4);
        e_bit = e_val ? bt[n-4] : 0;
        @(negedge clk);
        sym_valid = 1'b0; sym_pos = 1'b0; sym_neg = 1'b0;
        chk("R4 dout_valid", int'(dout_valid), e_val);
        if (e_val) begin
            chk("R1/R2/R3 dout_bit", int'(dout_bit), e_bit);
            if (use_orig && (n - 4) < orig.size())
                chk("R5 round trip", int'(dout_bit), orig[n-4]);
        end
        chk("R6/R7 code_err", int'(code_err), e_err);
    endtask

    task automatic gap();
        @(negedge clk);
        chk("R9 idle valid", int'(dout_valid), 0);
        chk("R9 idle err", int'(code_err), 0);
    endtask

    // HDB3 encoder for R5, starting with last polarity negative
    task automatic send_encoded(input int len, input int seed_mode);
        int sym[$];
        int pol, cnt, zrun, b;
        pol = -1; cnt = 0; zrun = 0;
        for (int i = 0; i < len; i++) begin
            if (seed_mode == 0) b = ($urandom_range(0, 3) == 0) ? 1 : 0;
            else b = $urandom_range(0, 1);
            orig.push_back(b);
            if (b) begin
                pol = -pol; cnt++; zrun = 0; sym.push_back(pol);
            end else begin
                zrun++; sym.push_back(0);
                if (zrun == 4) begin
                    if (cnt % 2 == 0) begin
                        pol = -pol; sym[i-3] = pol;
                    end
                    sym[i] = pol; cnt = 0; zrun = 0;
                end
            end
        end
        use_orig = 1;
        for (int i = 0; i < len; i++) begin
            send(sym[i]);
            if (i % 17 == 5) gap();
        end
        for (int i = 0; i < 4; i++) send(0);
        use_orig = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; sym_valid = 1'b0; sym_pos = 1'b0; sym_neg = 1'b0;
        model_reset();
        do_reset();
        // R1: alternate marks and zeros
        send(1); send(0); send(-1); send(1); send(0); send(-1); send(0);
        // R2: violation right after reset (negative), then repeated polarity
        do_reset();
        send(-1); send(1); send(1); send(0); send(-1); send(0); send(0);
        send(0); send(0);
        // R3: B00V at start and back to back
        do_reset();
        send(1); send(0); send(0); send(1); send(-1); send(0); send(0); send(-1);
        send(0); send(0); send(0); send(0); send(0);
        // R6: both lines high, polarity unchanged afterwards
        send(2); send(-1); send(2); send(1); send(0); send(0); send(0); send(0);
        // R7: two positive violations in a row
        do_reset();
        send(1); send(1); send(0); send(1); send(-1); send(-1); send(0);
        send(0); send(0); send(0);
        // R9 gaps inside traffic
        send(1); gap(); gap(); send(1); gap(); send(0);
        // R8: reset in the middle of a filled window
        send(-1); send(0); do_reset();
        send(1); send(0); send(0); send(0); send(0);
        // R5: encoded streams
        do_reset();
        send_encoded(400, 0);
        do_reset();
        send_encoded(400, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule